// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the current time and date as seven BCD bytes: seconds, minutes, hours, day of week, date, month and two-digit year. A one-cycle `tick_i` pulse advances the time by one second. Each carry moves into the next field. The carries run from seconds to minutes to hours. At midnight they run to the date and the day of week together, then to the month and then to the year. The length of each month, including February in leap years, is worked out from the stored month and year.

The hours byte carries its own format. When bit 6 is set, the count runs 01 to 12 and bit 5 marks the afternoon. When bit 6 is clear, the count runs 00 to 23 and bit 5 is the tens bit for 20 to 23. A host sets any field through a synchronous one-byte write port. It reads any field through a combinational read port selected by an index. The field indices are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Index 7 is unused.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour format), day of week 01, date 01, month 01, year 00.
- R2: Each tick advances seconds in BCD from 00 to 59. From 59 the seconds return to 00 and the minutes advance. Minutes likewise run 00 to 59, and their wrap advances the hours.
- R3: With hours bit 6 clear, hours count 00 to 23. The step from 23 to 00 advances the date; no other hour step does.
- R4: With hours bit 6 set, bits 4..0 hold 01 to 12 and bit 5 is the PM flag. 11 AM goes to 12 PM without a date change. 11 PM goes to 12 AM and advances the date. 12 goes to 01 and keeps the flag. A tick never changes bit 6.
- R5: Day of week counts 01 to 07. It advances on the same tick that advances the date, and 07 wraps to 01.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. The wrap advances the month. Month 12 wraps to 01 and advances the year.
- R7: In month 02 the date wraps after 29 when the year value is a multiple of four, counting 00. In other years it wraps after 28.
- R8: Year counts 00 to 99 in BCD, and 99 wraps to 00.
- R9: A write to a field in the same cycle as a tick loads that field with the written byte. The other fields still follow the tick.
- R10: Bits outside each field always read 0. The writable bits are 6..0 for seconds, minutes and hours, 2..0 for day of week, 5..0 for date, 4..0 for month, and 7..0 for year. Index 7 reads 00, and a write to index 7 changes nothing.
- R11: In a cycle with neither a tick nor a write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| wr_en_i | input | 1 | Field write strobe |
| wr_idx_i | input | 3 | Field index for the write |
| wr_data_i | input | 8 | BCD byte to write |
| rd_idx_i | input | 3 | Field index for the read |
| rd_data_o | output | 8 | BCD byte of the selected field |

## Verification
Seconds are swept through a full minute, and every one of the 24 hours is stepped once in each hour format. Only the 23:00 and 11 PM steps may move the date, so an early or missing midnight carry shows up, as does a wrong 11 AM or 12 o'clock transition. Every month end is driven in a non-leap year, with the day before each end as a control, and February 28 is stepped in all hundred years. Together these separate a wrong month-length table from a wrong divisibility test. A tick combined with a write, all-ones writes to each index, and idle cycles cover write priority, bit masking and holding.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   localparam int FIELD_CNT = 7;

   typedef enum logic [2:0] {
      FX_SEC   = 3'd0,
      FX_MIN   = 3'd1,
      FX_HOUR  = 3'd2,
      FX_WDAY  = 3'd3,
      FX_DATE  = 3'd4,
      FX_MONTH = 3'd5,
      FX_YEAR  = 3'd6,
      FX_NONE  = 3'd7
   } field_e;

   // add one to a two-digit BCD byte (no range limit)
   function automatic logic [7:0] bcd_incr(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // bits that a field keeps; all others read back as zero
   function automatic logic [7:0] field_mask(input logic [2:0] idx);
      logic [7:0] m;
      case (idx)
         FX_SEC, FX_MIN, FX_HOUR: m = 8'h7F;
         FX_WDAY:                 m = 8'h07;
         FX_DATE:                 m = 8'h3F;
         FX_MONTH:                m = 8'h1F;
         FX_YEAR:                 m = 8'hFF;
         default:                 m = 8'h00;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
   parameter int           DW    = 8,
   parameter logic [DW-1:0] FLOOR = '0
) (
   input  logic [DW-1:0] cur_i,
   input  logic [DW-1:0] top_i,
   output logic [DW-1:0] nxt_o,
   output logic          wrap_o
);
   generate
      if (DW != 8) begin : g_bad_width
         $error("cal_bcd_step supports two BCD digits only");
      end
   endgenerate

   always_comb begin
      wrap_o = (cur_i >= top_i);
      nxt_o  = wrap_o ? FLOOR : bcd_cal_pkg::bcd_incr(cur_i);
   end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step (
   input  logic [7:0] hr_i,
   output logic [7:0] hr_o,
   output logic       day_o
);
   logic [7:0] cnt;
   logic [7:0] res;
   logic       pm_n;

   always_comb begin
      day_o = 1'b0;
      pm_n  = hr_i[5];
      res   = 8'h00;
      cnt   = 8'h00;
      if (hr_i[6]) begin
         // 12-hour count lives in bits 4..0, bit 5 is the PM flag
         cnt = {3'b000, hr_i[4:0]};
         if (cnt == 8'h11) begin
            res   = 8'h12;
            pm_n  = ~hr_i[5];
            day_o = hr_i[5];
         end else if (cnt >= 8'h12) begin
            res = 8'h01;
         end else begin
            res = bcd_cal_pkg::bcd_incr(cnt);
         end
         hr_o = {1'b0, 1'b1, pm_n, res[4:0]};
      end else begin
         cnt = {2'b00, hr_i[5:0]};
         if (cnt >= 8'h23) begin
            res   = 8'h00;
            day_o = 1'b1;
         end else begin
            res = bcd_cal_pkg::bcd_incr(cnt);
         end
         hr_o = {2'b00, res[5:0]};
      end
   end
endmodule

// File: rtl/cal_month_last.sv
module cal_month_last (
   input  logic [7:0] month_i,
   input  logic [7:0] year_i,
   output logic [7:0] last_o
);
   logic [1:0] rem4;
   logic       leap;

   always_comb begin
      // 10 is 2 mod 4, so the year mod 4 is (2*tens + units) mod 4
      rem4 = {year_i[4], 1'b0} + year_i[1:0];
      leap = (rem4 == 2'd0);
      case (month_i)
         8'h02:                      last_o = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
         default:                    last_o = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import bcd_cal_pkg::*;

   localparam int NF = FIELD_CNT;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("bcd_calendar needs DATA_W of 8");
      end
      if ((1 << IDX_W) < NF) begin : g_bad_iw
         $error("bcd_calendar IDX_W too small for seven fields");
      end
   endgenerate

   logic [DATA_W-1:0] regs_q [NF];
   logic [DATA_W-1:0] upd    [NF];

   logic [7:0] sec_n, min_n, hr_n, wday_n, date_n, mon_n, yr_n;
   logic       sec_w, min_w, hr_day, wday_w, date_w, mon_w, yr_w;
   logic [7:0] last_date;
   logic       go_min, go_hr, go_day, go_mon, go_yr;

   cal_month_last u_last (
      .month_i (regs_q[FX_MONTH]),
      .year_i  (regs_q[FX_YEAR]),
      .last_o  (last_date)
   );

   cal_bcd_step #(.FLOOR(8'h00)) u_sec (
      .cur_i(regs_q[FX_SEC]), .top_i(8'h59), .nxt_o(sec_n), .wrap_o(sec_w));
   cal_bcd_step #(.FLOOR(8'h00)) u_min (
      .cur_i(regs_q[FX_MIN]), .top_i(8'h59), .nxt_o(min_n), .wrap_o(min_w));
   cal_hour_step u_hour (
      .hr_i(regs_q[FX_HOUR]), .hr_o(hr_n), .day_o(hr_day));
   cal_bcd_step #(.FLOOR(8'h01)) u_wday (
      .cur_i(regs_q[FX_WDAY]), .top_i(8'h07), .nxt_o(wday_n), .wrap_o(wday_w));
   cal_bcd_step #(.FLOOR(8'h01)) u_date (
      .cur_i(regs_q[FX_DATE]), .top_i(last_date), .nxt_o(date_n), .wrap_o(date_w));
   cal_bcd_step #(.FLOOR(8'h01)) u_mon (
      .cur_i(regs_q[FX_MONTH]), .top_i(8'h12), .nxt_o(mon_n), .wrap_o(mon_w));
   cal_bcd_step #(.FLOOR(8'h00)) u_year (
      .cur_i(regs_q[FX_YEAR]), .top_i(8'h99), .nxt_o(yr_n), .wrap_o(yr_w));

   // carry chain from seconds up to the year
   always_comb begin
      go_min = tick_i & sec_w;
      go_hr  = go_min & min_w;
      go_day = go_hr  & hr_day;
      go_mon = go_day & date_w;
      go_yr  = go_mon & mon_w;

      upd[FX_SEC]   = tick_i ? sec_n  : regs_q[FX_SEC];
      upd[FX_MIN]   = go_min ? min_n  : regs_q[FX_MIN];
      upd[FX_HOUR]  = go_hr  ? hr_n   : regs_q[FX_HOUR];
      upd[FX_WDAY]  = go_day ? wday_n : regs_q[FX_WDAY];
      upd[FX_DATE]  = go_day ? date_n : regs_q[FX_DATE];
      upd[FX_MONTH] = go_mon ? mon_n  : regs_q[FX_MONTH];
      upd[FX_YEAR]  = go_yr  ? yr_n   : regs_q[FX_YEAR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q[FX_SEC]   <= 8'h00;
         regs_q[FX_MIN]   <= 8'h00;
         regs_q[FX_HOUR]  <= 8'h00;
         regs_q[FX_WDAY]  <= 8'h01;
         regs_q[FX_DATE]  <= 8'h01;
         regs_q[FX_MONTH] <= 8'h01;
         regs_q[FX_YEAR]  <= 8'h00;
      end else begin
         for (int i = 0; i < NF; i++) begin
            if (wr_en_i && (int'(wr_idx_i) == i))
               regs_q[i] <= wr_data_i & field_mask(3'(i));
            else
               regs_q[i] <= upd[i];
         end
      end
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (int'(rd_idx_i) < NF) rd_mux = regs_q[rd_idx_i];
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rd_data_o = rd_q;
      end else begin : g_rd_comb
         assign rd_data_o = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
   parameter bit RD_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       wr_en_i,
   input logic [2:0] wr_idx_i,
   input logic [7:0] wr_data_i,
   input logic [2:0] rd_idx_i,
   input logic [7:0] rd_data_o,
   input logic [7:0] sec_q,
   input logic [7:0] hour_q,
   input logic [7:0] wday_q,
   input logic [7:0] date_q,
   input logic [7:0] month_q,
   input logic [7:0] year_q,
   input logic       day_go
);
   assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_en_i && sec_q == 8'h59) |=> (sec_q == 8'h00));

   assert_mode_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i) |=> $stable(hour_q[6]));

   assert_wday_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (day_go && !wr_en_i && wday_q == 8'h07) |=> (wday_q == 8'h01));

   assert_leap_feb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (day_go && !wr_en_i && month_q == 8'h02 && date_q == 8'h28 && year_q == 8'h00)
      |=> (date_q == 8'h29));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i == 3'd0) |=> (sec_q == ($past(wr_data_i) & 8'h7F)));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_en_i) |=> ($stable(sec_q) && $stable(hour_q) &&
                                 $stable(date_q) && $stable(year_q)));

   generate
      if (!RD_REG) begin : g_comb_rd
         assert_unused_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx_i == 3'd7) |-> (rd_data_o == 8'h00));
      end
   endgenerate
endmodule

bind bcd_calendar bcd_calendar_chk #(.RD_REG(RD_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .wr_en_i   (wr_en_i),
   .wr_idx_i  (wr_idx_i),
   .wr_data_i (wr_data_i),
   .rd_idx_i  (rd_idx_i),
   .rd_data_o (rd_data_o),
   .sec_q     (regs_q[0]),
   .hour_q    (regs_q[2]),
   .wday_q    (regs_q[3]),
   .date_q    (regs_q[4]),
   .month_q   (regs_q[5]),
   .year_q    (regs_q[6]),
   .day_go    (go_day)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_idx_i = 3'd0;
   logic [7:0] wr_data_i = 8'h00;
   logic [2:0] rd_idx_i = 3'd0;
   logic [7:0] rd_data_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bcd_calendar uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i),
      .rd_data_o(rd_data_o));

   function automatic logic [7:0] to_bcd(input int n);
      return 8'(((n / 10) << 4) | (n % 10));
   endfunction

   function automatic logic [7:0] enc12(input int h);
      int h12;
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
   endfunction

   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic put(input int idx, input logic [7:0] d);
      wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_data_i = d;
      cyc();
      wr_en_i = 1'b0;
   endtask

   task automatic pulse();
      tick_i = 1'b1;
      cyc();
      tick_i = 1'b0;
   endtask

   task automatic chk(input string req, input int idx, input logic [7:0] exp);
      rd_idx_i = 3'(idx);
      #1;
      total++;
      if (rd_data_o !== exp) begin
         bad++;
         $display("FAIL %s field %0d: actual %h expected %h", req, idx, rd_data_o, exp);
      end
   endtask

   task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y);
      put(0, s); put(1, mi); put(2, h); put(3, wd); put(4, d); put(5, mo); put(6, y);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00);
      chk("R1", 3, 8'h01); chk("R1", 4, 8'h01); chk("R1", 5, 8'h01);
      chk("R1", 6, 8'h00);

      // R2 full minute of seconds
      set_all(8'h00, 8'h00, 8'h10, 8'h02, 8'h05, 8'h03, 8'h21);
      for (int k = 0; k < 60; k++) begin
         pulse();
         chk("R2", 0, to_bcd((k + 1) % 60));
      end
      chk("R2", 1, 8'h01);
      put(0, 8'h59); put(1, 8'h59);
      pulse();
      chk("R2", 1, 8'h00); chk("R2", 2, 8'h11);

      // R3 every hour in 24-hour format
      for (int h = 0; h < 24; h++) begin
         set_all(8'h59, 8'h59, to_bcd(h), 8'h03, 8'h05, 8'h01, 8'h01);
         pulse();
         chk("R3", 2, to_bcd((h + 1) % 24));
         chk("R3", 4, (h == 23) ? 8'h06 : 8'h05);
      end

      // R4 every hour in 12-hour format
      for (int h = 0; h < 24; h++) begin
         set_all(8'h59, 8'h59, enc12(h), 8'h03, 8'h05, 8'h01, 8'h01);
         pulse();
         chk("R4", 2, enc12((h + 1) % 24));
         chk("R4", 4, (h == 23) ? 8'h06 : 8'h05);
         chk("R5", 3, (h == 23) ? 8'h04 : 8'h03);
      end

      // R5 day-of-week wrap at midnight
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h06, 8'h05);
      pulse();
      chk("R5", 3, 8'h01); chk("R5", 4, 8'h11);

      // R6 month ends in a non-leap year, with the day before as control
      for (int m = 1; m <= 12; m++) begin
         int last;
         last = mdays(m, 1);
         set_all(8'h59, 8'h59, 8'h23, 8'h02, to_bcd(last - 1), to_bcd(m), 8'h01);
         pulse();
         chk("R6", 4, to_bcd(last)); chk("R6", 5, to_bcd(m));
         set_all(8'h59, 8'h59, 8'h23, 8'h02, to_bcd(last), to_bcd(m), 8'h01);
         pulse();
         chk("R6", 4, 8'h01);
         chk("R6", 5, to_bcd((m % 12) + 1));
         chk("R6", 6, (m == 12) ? 8'h02 : 8'h01);
      end

      // R7 February 28 in every year
      for (int y = 0; y < 100; y++) begin
         set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, to_bcd(y));
         pulse();
         chk("R7", 4, (y % 4 == 0) ? 8'h29 : 8'h01);
         chk("R7", 5, (y % 4 == 0) ? 8'h02 : 8'h03);
      end

      // R8 year wrap
      set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99);
      pulse();
      chk("R8", 6, 8'h00); chk("R8", 5, 8'h01); chk("R8", 4, 8'h01);

      // R9 write together with tick
      set_all(8'h10, 8'h20, 8'h08, 8'h02, 8'h14, 8'h07, 8'h30);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = 3'd0; wr_data_i = 8'hC5;
      cyc();
      tick_i = 1'b0; wr_en_i = 1'b0;
      chk("R9", 0, 8'h45);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = 3'd6; wr_data_i = 8'h37;
      cyc();
      tick_i = 1'b0; wr_en_i = 1'b0;
      chk("R9", 0, 8'h46); chk("R9", 6, 8'h37);

      // R10 masks and unused index
      put(0, 8'hFF); chk("R10", 0, 8'h7F);
      put(1, 8'hFF); chk("R10", 1, 8'h7F);
      put(2, 8'hFF); chk("R10", 2, 8'h7F);
      put(3, 8'hFF); chk("R10", 3, 8'h07);
      put(4, 8'hFF); chk("R10", 4, 8'h3F);
      put(5, 8'hFF); chk("R10", 5, 8'h1F);
      put(6, 8'hFF); chk("R10", 6, 8'hFF);
      set_all(8'h12, 8'h34, 8'h15, 8'h05, 8'h19, 8'h08, 8'h44);
      put(7, 8'hAB);
      chk("R10", 7, 8'h00);
      chk("R10", 0, 8'h12); chk("R10", 1, 8'h34); chk("R10", 2, 8'h15);
      chk("R10", 3, 8'h05); chk("R10", 4, 8'h19); chk("R10", 5, 8'h08);
      chk("R10", 6, 8'h44);

      // R11 idle cycles
      repeat (5) cyc();
      chk("R11", 0, 8'h12); chk("R11", 1, 8'h34); chk("R11", 2, 8'h15);
      chk("R11", 4, 8'h19); chk("R11", 6, 8'h44);

      finished = 1'b1;
      report();
   end
endmodule